// File: doc/BRIEF.md
# Shared-Prescaler Pin Debounce Filter

This block cleans up a 32-bit bank of already-synchronized input pins before they reach edge and level detection. A single programmable prescaler divides the bus clock into one common sample tick. Every pin that is filtered is sampled on that tick, so all filtered pins share the same debounce interval. A pin's output moves to a new level only after that level has been seen on two ticks in a row. A glitch that does not last across two consecutive ticks therefore never reaches the output.

Two memory-mapped registers set up the filter. One holds a filter enable bit for each pin. The other holds the 24-bit prescale divisor. A pin is filtered only when its enable bit is set and its interrupt-enable input is also high, because filtering only matters on the interrupt path. Any other pin passes straight through with no register in its path.

Each pin has a small state machine with two states. FLT_STEADY means the output agrees with the last sample. FLT_PENDING means one tick has seen a different level. The state machine moves as follows:
- From FLT_STEADY to FLT_PENDING on a tick where the raw level differs from the output.
- From FLT_PENDING back to FLT_STEADY on the next tick. If the raw level still differs at that tick, the output takes the new level (the commit transition). If the raw level is back, the output is left as it was (the cancel transition).
- From either state back to FLT_STEADY in any cycle where the pin is not filtered. This is the bypass transition, and during it the stored output copies the raw pin.

Top module: `pin_debounce_filter`

## Requirements
- R1: A write (`reg_wr` high at a clock edge) to offset 0x40 loads the per-pin filter enables (bit i controls pin i). A write to offset 0x44 loads the prescale divisor. `reg_rdata` returns the addressed register in the same cycle, and any other offset reads 0.
- R2: The divisor register holds only bits 23:0 of the written word. Bits 31:24 are dropped and read back as 0.
- R3: A prescale counter runs from 0 up to D-1 and then wraps to 0. The common tick is high in the cycle the counter equals D-1, so with a steady divisor D there is one tick every D cycles. A divisor of 0 or 1 gives a tick in every cycle.
- R4: A write to the divisor register sets the counter to 0 in the next cycle, whatever value it held before.
- R5: A pin is filtered when both its enable bit and its `irq_en` bit are 1. When a pin is not filtered, `pin_out` for that pin equals `pin_in` in the same cycle.
- R6: Reset (synchronous, active-high `rst`) clears the enable register and the divisor register to 0, and puts every pin in FLT_STEADY with a stored output of 0.
- R7: A filtered pin's output changes only at a clock edge where the tick is high. It changes only when the raw level at that tick and at the previous tick both differ from the current output.
- R8: While a pin is not filtered, its stored output follows the raw pin every cycle and its state returns to FLT_STEADY. As a result, turning filtering on does not step the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_en | input | 32 | Per-pin interrupt enable from the detection logic |
| pin_in | input | 32 | Synchronized raw pin levels |
| pin_out | output | 32 | Conditioned pin levels to the detection logic |

## Verification
The assertions assume that `pin_in` and `irq_en` are already synchronous to `clk`. They also assume the register port sees at most one write per cycle and that `reg_addr` is stable whenever `reg_rdata` is sampled. The bench changes every input only at the falling clock edge and holds each write for exactly one cycle. It sweeps small divisors so that tick, commit and cancel transitions occur often, and it checks outputs against an arithmetic model of the counter and the two-state pin machine.

// File: rtl/pdf_pkg.sv
package pdf_pkg;
    typedef enum logic {
        FLT_STEADY  = 1'b0,
        FLT_PENDING = 1'b1
    } flt_state_e;

    localparam int unsigned PDF_ADDR_W  = 8;
    localparam int unsigned PDF_DATA_W  = 32;
    localparam logic [PDF_ADDR_W-1:0] PDF_OFS_ENABLE = 8'h40;
    localparam logic [PDF_ADDR_W-1:0] PDF_OFS_DIVIDE = 8'h44;
endpackage

// File: rtl/pdf_regs.sv
module pdf_regs
    import pdf_pkg::*;
#(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned DIV_W  = 24,
    parameter int unsigned ADDR_W = PDF_ADDR_W,
    parameter int unsigned DATA_W = PDF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NPINS-1:0]  en_q,
    output logic [DIV_W-1:0]  div_q,
    output logic              div_wr
);
    logic hit_en;
    logic hit_div;

    assign hit_en  = (addr == ADDR_W'(PDF_OFS_ENABLE));
    assign hit_div = (addr == ADDR_W'(PDF_OFS_DIVIDE));
    assign div_wr  = wr && hit_div;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            div_q <= '0;
        end else begin
            if (wr && hit_en) begin
                en_q <= wdata[NPINS-1:0];
            end
            if (div_wr) begin
                div_q <= wdata[DIV_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_en) begin
            rdata[NPINS-1:0] = en_q;
        end else if (hit_div) begin
            rdata[DIV_W-1:0] = div_q;
        end
    end
endmodule

// File: rtl/pdf_prescaler.sv
module pdf_prescaler #(
    parameter int unsigned DIV_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    input  logic             restart,
    output logic             tick,
    output logic [DIV_W-1:0] cnt
);
    logic [DIV_W-1:0] limit;
    logic [DIV_W-1:0] cnt_q;

    // A divisor of 0 behaves like 1: the limit is 0 and the tick is constant.
    assign limit = (div == '0) ? '0 : div - DIV_W'(1);
    assign tick  = (cnt_q == limit);
    assign cnt   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/pdf_pin_filter.sv
module pdf_pin_filter
    import pdf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic sel,
    input  logic raw,
    output logic filt
);
    flt_state_e st_q, st_d;
    logic       lvl_q, lvl_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= FLT_STEADY;
            lvl_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            lvl_q <= lvl_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        lvl_d = lvl_q;
        if (!sel) begin
            // bypass transition: track the pin so enabling causes no step
            st_d  = FLT_STEADY;
            lvl_d = raw;
        end else if (tick) begin
            unique case (st_q)
                FLT_STEADY: begin
                    if (raw != lvl_q) begin
                        st_d = FLT_PENDING;
                    end
                end
                FLT_PENDING: begin
                    st_d = FLT_STEADY;
                    if (raw != lvl_q) begin
                        lvl_d = raw;   // commit
                    end                // else cancel
                end
                default: st_d = FLT_STEADY;
            endcase
        end
    end

    assign filt = lvl_q;
endmodule

// File: rtl/pin_debounce_filter.sv
module pin_debounce_filter
    import pdf_pkg::*;
#(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned DIV_W  = 24,
    parameter int unsigned ADDR_W = PDF_ADDR_W,
    parameter int unsigned DATA_W = PDF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NPINS-1:0]  irq_en,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out
);
    logic [NPINS-1:0] en_q;
    logic [DIV_W-1:0] div_q;
    logic             div_wr;
    logic             tick;
    logic [DIV_W-1:0] presc_cnt;
    logic [NPINS-1:0] pin_sel;
    logic [NPINS-1:0] filt;

    pdf_regs #(
        .NPINS (NPINS),
        .DIV_W (DIV_W),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .en_q  (en_q),
        .div_q (div_q),
        .div_wr(div_wr)
    );

    pdf_prescaler #(
        .DIV_W(DIV_W)
    ) u_presc (
        .clk    (clk),
        .rst    (rst),
        .div    (div_q),
        .restart(div_wr),
        .tick   (tick),
        .cnt    (presc_cnt)
    );

    assign pin_sel = en_q & irq_en;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        pdf_pin_filter u_flt (
            .clk (clk),
            .rst (rst),
            .tick(tick),
            .sel (pin_sel[g]),
            .raw (pin_in[g]),
            .filt(filt[g])
        );
        assign pin_out[g] = pin_sel[g] ? filt[g] : pin_in[g];
    end
endmodule

// File: rtl/pin_debounce_filter_chk.sv
module pin_debounce_filter_chk
    import pdf_pkg::*;
#(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned DIV_W  = 24,
    parameter int unsigned ADDR_W = PDF_ADDR_W,
    parameter int unsigned DATA_W = PDF_DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [NPINS-1:0]  pin_in,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_sel,
    input logic [NPINS-1:0]  en_q,
    input logic [DIV_W-1:0]  div_q,
    input logic              div_wr,
    input logic              tick,
    input logic [DIV_W-1:0]  presc_cnt
);
    p_bypass_r5: assert property (@(posedge clk) disable iff (rst)
        ((~pin_sel) & (pin_out ^ pin_in)) == '0);

    p_quiet_between_ticks_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(tick) |-> ((pin_sel & $past(pin_sel)) & (pin_out ^ $past(pin_out))) == '0);

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_W'(PDF_OFS_DIVIDE)) |-> reg_rdata[DATA_W-1:DIV_W] == '0);

    p_reset_clear_r6: assert property (@(posedge clk)
        $fell(rst) |-> (en_q == '0 && div_q == '0));

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (div_q > DIV_W'(1)) |-> presc_cnt < div_q);

    p_restart_r4: assert property (@(posedge clk) disable iff (rst)
        div_wr |=> presc_cnt == '0);
endmodule

bind pin_debounce_filter pin_debounce_filter_chk #(
    .NPINS (NPINS),
    .DIV_W (DIV_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_sel  (pin_sel),
    .en_q     (en_q),
    .div_q    (div_q),
    .div_wr   (div_wr),
    .tick     (tick),
    .presc_cnt(presc_cnt)
);

// File: tb/pin_debounce_filter_tb_top.sv
module pin_debounce_filter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_addr = 8'h00;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] irq_en = '0;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // arithmetic model state
    logic [NP-1:0] m_en = '0, m_f = '0, m_p = '0;
    logic [23:0]   m_div = '0, m_cnt = '0;
    logic [31:0]   lfsr = 32'h1ACE_B00C;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_debounce_filter dut_i (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq_en   (irq_en),
        .pin_in   (pin_in),
        .pin_out  (pin_out)
    );

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        logic          tk;
        logic [NP-1:0] sel, nf, np, ne;
        logic [23:0]   nc, nd;
        #1;
        sel = m_en & irq_en;
        // R5 R7 R8: filtered pins show model level, others the raw pin
        check32("R5 R7 R8 pin_out", pin_out, (sel & m_f) | (~sel & pin_in));
        tk = (m_div <= 24'd1) || (m_cnt == m_div - 24'd1);
        nc = tk ? 24'd0 : m_cnt + 24'd1;
        nd = m_div;
        ne = m_en;
        if (reg_wr && reg_addr == 8'h44) begin nd = reg_wdata[23:0]; nc = 24'd0; end
        if (reg_wr && reg_addr == 8'h40) ne = reg_wdata;
        nf = m_f;
        np = m_p;
        for (int i = 0; i < NP; i++) begin
            if (!sel[i]) begin
                nf[i] = pin_in[i];
                np[i] = 1'b0;
            end else if (tk) begin
                if (!m_p[i]) begin
                    np[i] = (pin_in[i] != m_f[i]);
                end else begin
                    np[i] = 1'b0;
                    if (pin_in[i] != m_f[i]) nf[i] = pin_in[i];
                end
            end
        end
        @(posedge clk);
        m_f = nf; m_p = np; m_cnt = nc; m_div = nd; m_en = ne;
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    // run n cycles; pins flip sparsely, in bursts of random length
    task automatic run(input int n, input int density);
        for (int c = 0; c < n; c++) begin
            lfsr = nxt(lfsr);
            if (density == 0) pin_in = pin_in ^ (lfsr & nxt(lfsr) & nxt(nxt(lfsr)));
            else pin_in = pin_in ^ (lfsr & nxt(lfsr));
            step();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        pin_in = 32'h5A5A_3C3C;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R6: registers cleared after reset
        reg_addr = 8'h40; #1;
        check32("R6 enable reset", reg_rdata, 32'h0);
        reg_addr = 8'h44; #1;
        check32("R6 divisor reset", reg_rdata, 32'h0);
        // R5: unfiltered pins pass straight through
        pin_in = 32'hDEAD_BEEF; #1;
        check32("R5 raw passthrough", pin_out, 32'hDEAD_BEEF);
        step();
        // R1 R2: readback and upper-bit drop
        reg_write(8'h44, 32'hFF00_0007);
        reg_addr = 8'h44; #1;
        check32("R2 divisor masked", reg_rdata, 32'h0000_0007);
        reg_write(8'h40, 32'h1234_5678);
        reg_addr = 8'h40; #1;
        check32("R1 enable readback", reg_rdata, 32'h1234_5678);
        reg_addr = 8'h48; #1;
        check32("R1 unmapped reads zero", reg_rdata, 32'h0);
        reg_wr = 1'b1; reg_wdata = 32'hFFFF_FFFF; step(); reg_wr = 1'b0;
        reg_addr = 8'h40; #1;
        check32("R1 unmapped write ignored", reg_rdata, 32'h1234_5678);

        // R3 R4 R7 R8: sweep small divisors, gating and mid-run restarts
        for (int d = 0; d < 7; d++) begin
            reg_write(8'h40, 32'hA5A5_FFFF);
            irq_en = 32'hFFFF_0FF0;
            reg_write(8'h44, 32'(d));
            run(120, 0);
            run(60, 1);
            reg_write(8'h44, 32'(d));        // R4 restart with same divisor
            run(40, 1);
            irq_en = 32'h0F0F_F00F;          // R8 gating change mid-run
            run(80, 0);
            reg_write(8'h40, 32'h0000_0000); // R8 all bypass
            run(10, 1);
            reg_write(8'h40, 32'hFFFF_FFFF); // R8 enable all, no step
            irq_en = 32'hFFFF_FFFF;
            run(100, 0);
        end
        // R2 R3: large divisor with upper bits set, checked with restart
        reg_write(8'h44, 32'hAB00_0009);
        run(200, 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule